// File: doc/BRIEF.md
# FIFO-buffered SPI master

This block is a memory-mapped SPI master. Software writes bytes into a transmit queue and sets a run bit. The block then shifts each byte out MSB first on the serial clock, and every byte sent brings one received byte back into a receive queue. Each queue holds 16 entries. The serial clock rate comes from an even system-clock divider. Any of the four clock polarity/phase combinations can be selected. A 3-wire read mode takes incoming bits on the MOSI pad instead of MISO while the pad driver is off.

Software uses a simple single-cycle register port. A completion condition ("done") and a receive-level condition can each raise the interrupt output. Software normally enables the done interrupt, sets the run bit, fills the queue from the interrupt handler and drains received bytes. When finished, it clears the run bit and flushes both queues.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, a read of offset 0x00 returns 0x0004_0000 (only bit 18 set), sclk_o is 0, cs_n_o is 1, irq_o is 0 and mosi_oe_o is 1.
- R2: Offset 0x00 bit 3 sets clock polarity and bit 2 sets clock phase. sclk_o rests at the polarity value whenever no byte is in flight. Each byte is 8 bits, MSB first. Phase 0 samples on the leading edge and phase 1 samples on the trailing edge. Every byte sent pushes exactly one received byte.
- R3: Offset 0x08 holds a 16-bit divider whose bit 0 is ignored. Each half serial-clock period lasts value/2 system clocks. An even value of 0 (written as 0 or 1) gives 32768 clocks per half period.
- R4: Offset 0x00 bit 7 (run) holds cs_n_o low while set. Bytes leave the transmit queue only while run is set. Clearing run abandons a byte in flight without pushing anything into the receive queue.
- R5: Status bit 16 (done) reads 1 exactly when run is set, the transmit queue is empty and no byte is in flight. Setting run with an empty queue sets done at once.
- R6: Offset 0x00 status bits are: 17 = receive queue not empty, 18 = transmit queue not full, 19 = receive queue holds 12 or more bytes, 20 = receive queue full.
- R7: irq_o = (bit 9 AND done) OR (bit 10 AND status bit 19).
- R8: Writing 1 to offset 0x00 bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue. Both bits always read back as 0.
- R9: Writing offset 0x04 pushes wdata_i[7:0] into the transmit queue, and the write is dropped when the queue is full. Reading offset 0x04 pops the receive queue, and reading it while empty returns 0 and changes nothing.
- R10: No byte starts while the receive queue is full. Shifting resumes once a byte is read out.
- R11: With offset 0x00 bit 12 set, mosi_oe_o is 0 and received bits come from mosi_i rather than miso_i.
- R12: Offset 0x0C is a 16-bit register that reads back as written and has no effect on transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_o | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for the MOSI pad |
| mosi_i | input | 1 | MOSI pad input, used in 3-wire read mode |
| miso_i | input | 1 | Serial data in |

## Verification
A bench-side SPI slave model carries a table of single-byte transfers through all four polarity/phase pairs. The transmit and reply patterns are asymmetric, so a bit-order, phase or sampling-edge error changes the bytes seen at both ends. The same table uses even, odd and larger dividers; the odd one shows that bit 0 is dropped. A zero-divider run measures the 32768-clock half period and is then abandoned. Multi-byte bursts step the receive level across the 12-entry threshold and into the full stall. The 3-wire run drives miso_i with the inverse of mosi_i, so taking data from the wrong pin yields the complemented byte.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int BUS_W = 32;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_DATA = 4'h4;
  localparam logic [3:0] OFS_DIV  = 4'h8;
  localparam logic [3:0] OFS_LEN  = 4'hC;

  localparam int B_CPHA    = 2;
  localparam int B_CPOL    = 3;
  localparam int B_CLR_TX  = 4;
  localparam int B_CLR_RX  = 5;
  localparam int B_RUN     = 7;
  localparam int B_IE_DONE = 9;
  localparam int B_IE_RXR  = 10;
  localparam int B_REN     = 12;
  localparam int B_DONE    = 16;
  localparam int B_RXD     = 17;
  localparam int B_TXD     = 18;
  localparam int B_RXR     = 19;
  localparam int B_RXF     = 20;

  typedef struct packed {
    logic ren;
    logic ie_rxr;
    logic ie_done;
    logic run;
    logic cpol;
    logic cpha;
  } ctrl_t;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       pop_i,
  output logic [W-1:0]               rdata_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH):0]     cnt_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rp_q, wp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop)  rp_q <= rp_q + AW'(1);
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q, limit;

  // bit 0 dropped; a zero even value selects the slowest rate
  always_comb begin
    if (div_i[DW-1:1] == '0) limit = {1'b1, {(DW-1){1'b0}}} - DW'(1);
    else                     limit = {1'b0, div_i[DW-1:1]} - DW'(1);
  end

  assign tick_o = run_i & (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + DW'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         cpol_i,
  input  logic         cpha_i,
  input  logic         tick_i,
  input  logic         tx_avail_i,
  input  logic         rx_room_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         din_i,
  output logic         tx_pop_o,
  output logic         rx_push_o,
  output logic [W-1:0] rx_data_o,
  output logic         sclk_o,
  output logic         dout_o,
  output logic         busy_o
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);

  logic          busy_q, ph_q;
  logic [EW-1:0] edge_q;
  logic [W-1:0]  tx_sh_q, rx_sh_q, rx_nxt;
  logic          lead, samp, shft, last, step;

  always_comb begin
    lead   = ~edge_q[0];
    samp   = lead ^ cpha_i;
    // phase 1 already presents the MSB before the first leading edge
    shft   = ~samp & ~(cpha_i & (edge_q == '0));
    last   = (edge_q == EW'(EDGES - 1));
    step   = busy_q & en_i & tick_i;
    rx_nxt = {rx_sh_q[W-2:0], din_i};
  end

  assign tx_pop_o  = en_i & ~busy_q & tx_avail_i & rx_room_i;
  assign rx_push_o = step & last;
  assign rx_data_o = samp ? rx_nxt : rx_sh_q;
  assign sclk_o    = cpol_i ^ ph_q;
  assign dout_o    = tx_sh_q[W-1];
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ph_q    <= 1'b0;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (tx_pop_o) begin
      busy_q  <= 1'b1;
      ph_q    <= 1'b0;
      edge_q  <= '0;
      tx_sh_q <= tx_data_i;
    end else if (busy_q && !en_i) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
    end else if (step) begin
      ph_q   <= ~ph_q;
      edge_q <= edge_q + EW'(1);
      if (samp) rx_sh_q <= rx_nxt;
      if (shft) tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
      if (last) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16,
  parameter int LEN_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             mosi_i,
  input  logic             miso_i
);
  localparam int AW      = $clog2(FIFO_DEPTH);
  localparam int RXR_LVL = FIFO_DEPTH * 3 / 4;

  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;

  logic wr, rd, wr_ctrl, wr_data, rd_data;
  logic tick, busy, done, rxr, din;
  logic tx_pop, rx_push;
  logic [DATA_W-1:0] rx_byte;

  // queue 0 = transmit, queue 1 = receive
  logic [1:0]        f_flush, f_push, f_pop, f_empty, f_full;
  logic [DATA_W-1:0] f_wdata [2];
  logic [DATA_W-1:0] f_rdata [2];
  logic [AW:0]       f_cnt   [2];

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_ctrl = wr & (addr_i == OFS_CTRL);
  assign wr_data = wr & (addr_i == OFS_DATA);
  assign rd_data = rd & (addr_i == OFS_DATA);

  assign f_flush    = {wr_ctrl & wdata_i[B_CLR_RX], wr_ctrl & wdata_i[B_CLR_TX]};
  assign f_push     = {rx_push, wr_data};
  assign f_pop      = {rd_data, tx_pop};
  assign f_wdata[0] = wdata_i[DATA_W-1:0];
  assign f_wdata[1] = rx_byte;

  for (genvar g = 0; g < 2; g++) begin : g_fifo
    spi_sync_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (f_flush[g]),
      .push_i  (f_push[g]),
      .wdata_i (f_wdata[g]),
      .pop_i   (f_pop[g]),
      .rdata_o (f_rdata[g]),
      .empty_o (f_empty[g]),
      .full_o  (f_full[g]),
      .cnt_o   (f_cnt[g])
    );
  end

  spi_half_tick #(.DW(DIV_W)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_q),
    .tick_o (tick)
  );

  assign din = ctrl_q.ren ? mosi_i : miso_i;

  spi_shift_engine #(.W(DATA_W)) eng_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q.run),
    .cpol_i     (ctrl_q.cpol),
    .cpha_i     (ctrl_q.cpha),
    .tick_i     (tick),
    .tx_avail_i (~f_empty[0]),
    .rx_room_i  (~f_full[1]),
    .tx_data_i  (f_rdata[0]),
    .din_i      (din),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_byte),
    .sclk_o     (sclk_o),
    .dout_o     (mosi_o),
    .busy_o     (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
      len_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        OFS_CTRL: begin
          ctrl_q.cpha    <= wdata_i[B_CPHA];
          ctrl_q.cpol    <= wdata_i[B_CPOL];
          ctrl_q.run     <= wdata_i[B_RUN];
          ctrl_q.ie_done <= wdata_i[B_IE_DONE];
          ctrl_q.ie_rxr  <= wdata_i[B_IE_RXR];
          ctrl_q.ren     <= wdata_i[B_REN];
        end
        OFS_DIV: div_q <= wdata_i[DIV_W-1:0];
        OFS_LEN: len_q <= wdata_i[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  assign done      = ctrl_q.run & f_empty[0] & ~busy;
  assign rxr       = (f_cnt[1] >= (AW+1)'(RXR_LVL));
  assign irq_o     = (ctrl_q.ie_done & done) | (ctrl_q.ie_rxr & rxr);
  assign cs_n_o    = ~ctrl_q.run;
  assign mosi_oe_o = ~ctrl_q.ren;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        OFS_CTRL: begin
          rdata_o[B_CPHA]    = ctrl_q.cpha;
          rdata_o[B_CPOL]    = ctrl_q.cpol;
          rdata_o[B_RUN]     = ctrl_q.run;
          rdata_o[B_IE_DONE] = ctrl_q.ie_done;
          rdata_o[B_IE_RXR]  = ctrl_q.ie_rxr;
          rdata_o[B_REN]     = ctrl_q.ren;
          rdata_o[B_DONE]    = done;
          rdata_o[B_RXD]     = ~f_empty[1];
          rdata_o[B_TXD]     = ~f_full[0];
          rdata_o[B_RXR]     = rxr;
          rdata_o[B_RXF]     = f_full[1];
        end
        OFS_DATA: if (!f_empty[1]) rdata_o[DATA_W-1:0] = f_rdata[1];
        OFS_DIV:  rdata_o[DIV_W-1:0] = div_q;
        OFS_LEN:  rdata_o[LEN_W-1:0] = len_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk
  import spi_fifo_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [3:0]       addr_i,
  input logic [BUS_W-1:0] wdata_i,
  input logic [BUS_W-1:0] rdata_o,
  input logic             sclk_o,
  input logic             cs_n_o,
  input logic             cpol_i,
  input logic             busy_i,
  input logic             tx_pop_i,
  input logic             tx_full_i,
  input logic             tx_empty_i,
  input logic             rx_push_i,
  input logic             rx_full_i,
  input logic             rx_empty_i
);
  AST_IDLE_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (sclk_o == cpol_i)); // R2

  AST_NO_RX_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_i |-> !rx_push_i); // R10

  AST_TX_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_i && req_i && we_i && addr_i == OFS_DATA && !tx_pop_i) |=> tx_full_i); // R9

  AST_CLR_TX_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_CTRL && wdata_i[B_CLR_TX]) |=> tx_empty_i); // R8

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_DATA && rx_empty_i) |-> (rdata_o == '0)); // R9

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |=> !busy_i); // R4
endmodule

bind spi_fifo_master spi_fifo_master_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .sclk_o     (sclk_o),
  .cs_n_o     (cs_n_o),
  .cpol_i     (ctrl_q.cpol),
  .busy_i     (busy),
  .tx_pop_i   (tx_pop),
  .tx_full_i  (f_full[0]),
  .tx_empty_i (f_empty[0]),
  .rx_push_i  (rx_push),
  .rx_full_i  (f_full[1]),
  .rx_empty_i (f_empty[1])
);

// File: tb/spi_fifo_master_tb_top.sv
module spi_fifo_master_tb_top;
  logic        clk, rst_n;
  logic        req, we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, sclk, cs_n, mosi, mosi_oe, mosi_in, miso;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // slave model state
  logic [7:0] s_tx = 8'h00, s_rx = 8'h00, s_pat = 8'h00;
  logic       cur_cpha = 1'b0, inv_miso = 1'b0;
  int         s_edges = 0, s_last = 0, s_half = 0, s_bytes = 0;

  // {cpol, cpha, divider, tx byte, slave reply}
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 8'd2,  8'hA5, 8'h3C},
    {2'b01, 8'd4,  8'h5A, 8'hC3},
    {2'b10, 8'd6,  8'h81, 8'h7E},
    {2'b11, 8'd2,  8'hF0, 8'h0F},
    {2'b00, 8'd5,  8'h01, 8'h80},
    {2'b11, 8'd10, 8'h6D, 8'hB2}
  };

  spi_fifo_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sclk_o(sclk),
    .cs_n_o(cs_n), .mosi_o(mosi), .mosi_oe_o(mosi_oe), .mosi_i(mosi_in),
    .miso_i(miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mosi_in = s_tx[7];
  assign miso    = s_tx[7] ^ inv_miso;

  always @(sclk) begin
    if (rst_n && !cs_n) begin
      if (((s_edges % 2) == 0) ^ cur_cpha) s_rx = {s_rx[6:0], mosi};
      else if (!(cur_cpha && s_edges == 0)) s_tx = {s_tx[6:0], 1'b0};
      if (s_edges == 1) s_half = cyc - s_last;
      s_last  = cyc;
      s_edges = s_edges + 1;
      if (s_edges == 16) begin
        s_edges = 0;
        s_tx    = s_pat;
        s_bytes = s_bytes + 1;
      end
    end
  end

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    logic [31:0] v;
    for (int i = 0; i < lim; i++) begin
      bus_rd(4'h0, v);
      if (v[16]) break;
    end
  endtask

  task automatic slave_arm(input logic [7:0] pat, input logic cpha);
    s_pat = pat; s_tx = pat; cur_cpha = cpha;
    s_edges = 0; s_bytes = 0; s_rx = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hexp;
    req = 0; we = 0; addr = 0; wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(4'h0, v);
    chk("R1 status", v, 32'h0004_0000);
    chk("R1 pins", {28'd0, sclk, cs_n, irq, mosi_oe}, {28'd0, 4'b0101});

    // R12 length register: read back; the table below runs with it set
    bus_wr(4'hC, 32'h0000_0003);
    bus_rd(4'hC, v);
    chk("R12 length", v, 32'h0000_0003);

    // table walk: R2 modes, R3 divider
    for (int i = 0; i < NV; i++) begin
      logic [1:0] md;
      logic [7:0] dv, tb_tx, pat;
      {md, dv, tb_tx, pat} = VEC[i];
      bus_wr(4'h0, 32'h0);
      bus_wr(4'h0, {28'd0, md[1], md[0], 2'b00});
      slave_arm(pat, md[0]);
      bus_wr(4'h8, {24'd0, dv});
      bus_wr(4'h4, {24'd0, tb_tx});
      bus_wr(4'h0, {24'd0, 1'b1, 3'b000, md[1], md[0], 2'b00});
      chk("R4 cs low", {31'd0, cs_n}, 32'd0);
      wait_done(400);
      hexp = (int'(dv) & ~1) / 2;
      chk("R2 mosi byte", {24'd0, s_rx}, {24'd0, tb_tx});
      chk("R2 byte count", s_bytes, 1);
      chk("R3 half period", s_half, hexp);
      bus_rd(4'h4, v);
      chk("R2 rx byte", v, {24'd0, pat});
      chk("R2 idle sclk", {31'd0, sclk}, {31'd0, md[1]});
    end

    // R5/R7/R8: clear tx, then run with empty queue
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h8, 32'd2);
    slave_arm(8'h00, 1'b0);
    bus_wr(4'h4, 32'h11);
    bus_wr(4'h4, 32'h22);
    bus_wr(4'h0, 32'h0000_0010);
    bus_rd(4'h0, v);
    chk("R8 clear bits read 0", v & 32'h30, 32'h0);
    bus_wr(4'h0, 32'h0000_0080);
    bus_rd(4'h0, v);
    chk("R5 done at once", v[16], 1'b1);
    chk("R8 tx flushed, no rx", v[17], 1'b0);
    chk("R7 irq off without enable", irq, 1'b0);
    bus_wr(4'h0, 32'h0000_0280);
    @(negedge clk);
    chk("R7 done irq", irq, 1'b1);

    // R6/R7: receive level threshold
    bus_wr(4'h0, 32'h0);
    slave_arm(8'hC9, 1'b0);
    for (int i = 0; i < 11; i++) bus_wr(4'h4, i);
    bus_wr(4'h0, 32'h0000_0480);
    wait_done(400);
    bus_rd(4'h0, v);
    chk("R6 level below 12", {v[20:17]}, 4'b0011);
    chk("R7 rxr irq low", irq, 1'b0);
    bus_wr(4'h4, 32'd11);
    wait_done(400);
    bus_rd(4'h0, v);
    chk("R6 level 12", {v[20:17]}, 4'b0111);
    @(negedge clk);
    chk("R7 rxr irq", irq, 1'b1);

    // R10: fill receive queue, one byte left waiting
    for (int i = 12; i < 17; i++) bus_wr(4'h4, i);
    repeat (200) @(negedge clk);
    bus_rd(4'h0, v);
    chk("R10 full, not done", {v[20], v[16]}, 2'b10);
    chk("R10 bytes sent", s_bytes, 16);
    bus_rd(4'h4, v);
    chk("R10 pop", v, 32'h0000_00C9);
    wait_done(400);
    chk("R10 resumed", s_bytes, 17);
    for (int i = 0; i < 16; i++) bus_rd(4'h4, v);
    bus_rd(4'h4, v);
    chk("R9 empty read 0", v, 32'h0);
    bus_rd(4'h0, v);
    chk("R9 empty read no effect", v[17], 1'b0);

    // R9: 17th write to a full transmit queue is dropped
    bus_wr(4'h0, 32'h0);
    slave_arm(8'h5C, 1'b0);
    for (int i = 0; i < 17; i++) bus_wr(4'h4, 32'h40 + i);
    bus_rd(4'h0, v);
    chk("R6 tx full", v[18], 1'b0);
    bus_wr(4'h0, 32'h0000_0080);
    wait_done(600);
    chk("R9 overflow dropped", s_bytes, 16);
    chk("R9 last byte sent", {24'd0, s_rx}, 32'h4F);
    bus_wr(4'h0, 32'h0000_00A0);
    bus_rd(4'h0, v);
    chk("R8 rx flushed", v[17], 1'b0);

    // R11: 3-wire read
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h0, 32'h0000_1000);
    chk("R11 oe off", mosi_oe, 1'b0);
    slave_arm(8'h96, 1'b0);
    inv_miso = 1'b1;
    bus_wr(4'h4, 32'h0);
    bus_wr(4'h0, 32'h0000_1080);
    wait_done(400);
    bus_rd(4'h4, v);
    chk("R11 data from mosi pad", v, 32'h96);
    inv_miso = 1'b0;

    // R3/R4: zero divider, then abort mid byte
    bus_wr(4'h0, 32'h0);
    slave_arm(8'hFF, 1'b0);
    bus_wr(4'h8, 32'd0);
    bus_wr(4'h4, 32'h77);
    bus_wr(4'h0, 32'h0000_0080);
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (s_edges >= 2) break;
    end
    chk("R3 zero divider half", s_half, 32768);
    bus_wr(4'h0, 32'h0);
    repeat (3) @(negedge clk);
    bus_rd(4'h0, v);
    chk("R4 abort no rx", v[17], 1'b0);
    chk("R4 cs released", {sclk, cs_n}, 2'b01);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule